// File: doc/BRIEF.md
# Credit-Gated In-Order Dispatch Stage

This block sits between a decode/rename stage and a set of execution targets. Decoded instructions, each carrying a tag and a target-unit code, are written into a bounded circular queue. On every cycle the block looks at the oldest entries and moves as many as it can, up to a configured width, into an outgoing dispatch group. The group goes to five execution targets (a floating-point unit, two integer ALUs, a branch unit and a load/store unit) and to a reorder buffer. Each consumer owns a pool of permission tokens. The block keeps a saturating counter of the tokens that each consumer has granted, spends one token per instruction sent, and never sends without one.

Issue is strictly in age order. When the oldest remaining entry targets a unit with no tokens left, the cycle's group ends at that entry, and the reason is kept on a stall-code output. Entries that target the reorder buffer itself need no execution token and leave already marked complete. Queue slots freed by dispatch are returned to the upstream stage as a credit count. After reset, the whole queue capacity is announced once. A flush empties the queue, hands every occupied slot back upstream, and cancels any group that is still on the output lanes, so that the tokens that group spent are recovered.

Top module: `credit_dispatch`

## Requirements
- R1: While reset is high and after it is released, `out_vld`, `stall_code` and `push_err` are zero. In the first cycle after reset is released, `up_cred_vld` is 1 and `up_cred_cnt` equals DEPTH.
- R2: Each consumer's token counter starts at zero after reset and grows by the value on its own add input. Execution-unit counters saturate at CRED_MAX, and the reorder-buffer counter saturates at ROB_MAX.
- R3: The number of entries considered in a cycle is the smallest of the queue occupancy, WIDTH and the reorder-buffer token count. With no reorder-buffer tokens, nothing is dispatched.
- R4: Entries are examined from the queue head in age order. The first entry whose execution target has no token left ends the group, even if younger entries could go. Dispatched entries fill lanes from lane 0 upward, oldest first.
- R5: `stall_code` uses 0 for not stalled, 1 for FPU busy, 2 for ALU0 busy, 3 for ALU1 busy, 4 for branch busy and 5 for load/store busy. In a cycle in which at least one entry is considered, it becomes the busy code of the target that ended the group, or 0 if no target did. In any other cycle it keeps its value.
- R6: Target codes 0 to 4 select FPU, ALU0, ALU1, branch and load/store. Code 5 targets the reorder buffer: such an entry spends no execution token and appears on its lane with `out_done` set.
- R7: Each dispatched entry spends one token of its target and leaves the queue. The group appears on the output lanes for exactly one cycle, the cycle after the decision, which is two cycles after the write when tokens are already present. In that same cycle `up_cred_vld` is 1 and `up_cred_cnt` equals the group size.
- R8: The reorder-buffer token counter drops by the full group size, code-5 entries included.
- R9: In a flush cycle no dispatch decision is made, the stall code is held, and the queue is emptied together with any writes accepted in that cycle. In the next cycle `up_cred_cnt` equals the occupancy plus those accepted writes.
- R10: A flush in the cycle in which a group is on the output lanes forces `out_vld` to zero and returns each masked lane's token to its execution unit. Reorder-buffer tokens are not returned.
- R11: A write of `in_cnt` entries is accepted up to the free space. One cycle after a write that asks for more than the free space, `push_err` pulses high, and the excess entries are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush |
| in_cnt | input | IW | Number of valid write slots this cycle, starting at slot 0 |
| in_tag | input | WIDTH*TAG_W | Per-slot instruction tag |
| in_tgt | input | WIDTH*3 | Per-slot target code |
| eu_cred_add | input | 5*CRED_W | Tokens granted by each execution unit, one field per unit code |
| rob_cred_add | input | CRED_W | Tokens granted by the reorder buffer |
| up_cred_vld | output | 1 | Queue-slot credit return strobe |
| up_cred_cnt | output | UPC_W | Queue slots returned upstream |
| out_vld | output | WIDTH | Dispatch lane valid |
| out_tag | output | WIDTH*TAG_W | Dispatch lane tag |
| out_tgt | output | WIDTH*3 | Dispatch lane target code |
| out_done | output | WIDTH | Lane entry completed at dispatch |
| stall_code | output | 3 | Recorded stall reason |
| push_err | output | 1 | Write overflow flag |

## Verification
The properties assume that target codes stay within 0 to 5, that `in_cnt` never exceeds WIDTH, and that a consumer only returns tokens it actually holds. They also assume that DEPTH is a power of two. The bench drives only legal target codes and at most two slots per cycle. It grants tokens in small amounts, so that saturation is reached on purpose rather than by wrap-around. The one deliberate overflow write is made against a full queue, to exercise the error path.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    localparam int TAG_W  = 8;
    localparam int TGT_W  = 3;
    localparam int NUM_EU = 5;

    // target codes: execution units first, reorder buffer last
    typedef enum logic [TGT_W-1:0] {
        TGT_FPU  = 3'd0,
        TGT_ALU0 = 3'd1,
        TGT_ALU1 = 3'd2,
        TGT_BR   = 3'd3,
        TGT_LSU  = 3'd4,
        TGT_ROB  = 3'd5
    } tgt_e;

    // busy code of a unit is its target code plus one
    typedef enum logic [2:0] {
        ST_NONE      = 3'd0,
        ST_FPU_BUSY  = 3'd1,
        ST_ALU0_BUSY = 3'd2,
        ST_ALU1_BUSY = 3'd3,
        ST_BR_BUSY   = 3'd4,
        ST_LSU_BUSY  = 3'd5
    } stall_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        tgt_e             tgt;
    } inst_t;

    function automatic logic is_eu(tgt_e t);
        return int'(t) < NUM_EU;
    endfunction

    function automatic stall_e busy_of(tgt_e t);
        return stall_e'(3'(int'(t) + 1));
    endfunction

endpackage

// File: rtl/dsp_queue.sv
// Circular instruction queue; DEPTH must be a power of two.
module dsp_queue
    import dsp_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [IW-1:0]    push_n,
    input  inst_t            push_d [WIDTH],
    input  logic [IW-1:0]    pop_n,
    output logic [CNT_W-1:0] occ,
    output inst_t            win [WIDTH]
);

    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    inst_t            mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            head <= head + PTR_W'(pop_n);
            tail <= tail + PTR_W'(push_n);
            occ  <= occ + CNT_W'(push_n) - CNT_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!clr) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i < int'(push_n)) mem[tail + PTR_W'(i)] <= push_d[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) win[i] = mem[head + PTR_W'(i)];
    end

endmodule

// File: rtl/dsp_credit.sv
// Saturating token counter: grants and reclaims add, dispatch subtracts.
module dsp_credit #(
    parameter int CW   = 4,
    parameter int MAXV = 15,
    parameter int UW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] add,
    input  logic [UW-1:0] take,
    input  logic [UW-1:0] back,
    output logic [CW-1:0] cnt
);

    localparam int SW = CW + 2;

    logic [SW-1:0] sum;

    always_comb sum = SW'(cnt) + SW'(add) + SW'(back) - SW'(take);

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (sum > SW'(MAXV)) cnt <= CW'(MAXV);
        else                     cnt <= CW'(sum);
    end

endmodule

// File: rtl/dsp_pick.sv
// Head-of-queue selection: age order, stop at first target without tokens.
module dsp_pick
    import dsp_pkg::*;
#(
    parameter int WIDTH = 2,
    parameter int CW    = 4,
    parameter int CNT_W = 4,
    parameter int UW    = 2
) (
    input  logic             en,
    input  inst_t            win [WIDTH],
    input  logic [CNT_W-1:0] occ,
    input  logic [CW-1:0]    rob_cnt,
    input  logic [CW-1:0]    eu_cnt [NUM_EU],
    output logic [WIDTH-1:0] go,
    output logic [WIDTH-1:0] done,
    output logic [UW-1:0]    n_go,
    output logic [UW-1:0]    eu_use [NUM_EU],
    output logic             st_upd,
    output stall_e           st_val
);

    int   lim;
    int   k;
    logic keep;

    always_comb begin
        lim = int'(occ);
        if (lim > WIDTH) lim = WIDTH;
        if (int'(rob_cnt) < lim) lim = int'(rob_cnt);
        keep   = 1'b1;
        k      = 0;
        go     = '0;
        done   = '0;
        n_go   = '0;
        st_val = ST_NONE;
        for (int e = 0; e < NUM_EU; e++) eu_use[e] = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (en && keep && i < lim) begin
                if (is_eu(win[i].tgt)) begin
                    k = int'(win[i].tgt);
                    if (int'(eu_cnt[k]) > int'(eu_use[k])) begin
                        go[i]     = 1'b1;
                        eu_use[k] = eu_use[k] + UW'(1);
                    end else begin
                        keep   = 1'b0;
                        st_val = busy_of(win[i].tgt);
                    end
                end else begin
                    go[i]   = 1'b1;
                    done[i] = 1'b1;
                end
                if (go[i]) n_go = n_go + UW'(1);
            end
        end
        st_upd = en && (lim > 0);
    end

endmodule

// File: rtl/credit_dispatch.sv
module credit_dispatch
    import dsp_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int WIDTH    = 2,
    parameter int CRED_W   = 4,
    parameter int CRED_MAX = 15,
    parameter int ROB_MAX  = 15,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(WIDTH + 1),
    localparam int UPC_W = $clog2(DEPTH + WIDTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [IW-1:0]            in_cnt,
    input  logic [WIDTH*TAG_W-1:0]   in_tag,
    input  logic [WIDTH*TGT_W-1:0]   in_tgt,
    input  logic [NUM_EU*CRED_W-1:0] eu_cred_add,
    input  logic [CRED_W-1:0]        rob_cred_add,
    output logic                     up_cred_vld,
    output logic [UPC_W-1:0]         up_cred_cnt,
    output logic [WIDTH-1:0]         out_vld,
    output logic [WIDTH*TAG_W-1:0]   out_tag,
    output logic [WIDTH*TGT_W-1:0]   out_tgt,
    output logic [WIDTH-1:0]         out_done,
    output logic [2:0]               stall_code,
    output logic                     push_err
);

    inst_t             in_d [WIDTH];
    inst_t             win [WIDTH];
    logic [CNT_W-1:0]  occ;
    logic [IW-1:0]     acc;
    logic [IW-1:0]     push_n;
    logic              over;
    int                eff_i;
    int                free_i;

    logic [CRED_W-1:0] eu_cnt  [NUM_EU];
    logic [IW-1:0]     eu_use  [NUM_EU];
    logic [IW-1:0]     eu_back [NUM_EU];
    logic [CRED_W-1:0] rob_cnt;

    logic [WIDTH-1:0]  go;
    logic [WIDTH-1:0]  done;
    logic [IW-1:0]     n_go;
    logic              st_upd;
    stall_e            st_val;

    inst_t             grp_q [WIDTH];
    logic [WIDTH-1:0]  vld_q;
    logic [WIDTH-1:0]  done_q;
    logic              init_q;
    stall_e            stall_q;
    logic              err_q;
    logic              upv_q;
    logic [UPC_W-1:0]  upc_q;
    int                ret_i;

    // unpack write slots and bound the write by the free space
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            in_d[i].tag = in_tag[i*TAG_W +: TAG_W];
            in_d[i].tgt = tgt_e'(in_tgt[i*TGT_W +: TGT_W]);
        end
        eff_i  = (int'(in_cnt) > WIDTH) ? WIDTH : int'(in_cnt);
        free_i = DEPTH - int'(occ);
        over   = eff_i > free_i;
        acc    = IW'(over ? free_i : eff_i);
        push_n = flush ? '0 : acc;
    end

    dsp_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .clr    (flush),
        .push_n (push_n),
        .push_d (in_d),
        .pop_n  (n_go),
        .occ    (occ),
        .win    (win)
    );

    dsp_pick #(.WIDTH(WIDTH), .CW(CRED_W), .CNT_W(CNT_W), .UW(IW)) u_pick (
        .en      (!flush),
        .win     (win),
        .occ     (occ),
        .rob_cnt (rob_cnt),
        .eu_cnt  (eu_cnt),
        .go      (go),
        .done    (done),
        .n_go    (n_go),
        .eu_use  (eu_use),
        .st_upd  (st_upd),
        .st_val  (st_val)
    );

    // tokens of a group cancelled on the lanes go back to their units
    always_comb begin
        for (int e = 0; e < NUM_EU; e++) begin
            eu_back[e] = '0;
            for (int i = 0; i < WIDTH; i++) begin
                if (flush && vld_q[i] && !done_q[i] && int'(grp_q[i].tgt) == e)
                    eu_back[e] = eu_back[e] + IW'(1);
            end
        end
    end

    for (genvar e = 0; e < NUM_EU; e++) begin : g_eu_cred
        dsp_credit #(.CW(CRED_W), .MAXV(CRED_MAX), .UW(IW)) u_cred (
            .clk  (clk),
            .rst  (rst),
            .add  (eu_cred_add[e*CRED_W +: CRED_W]),
            .take (eu_use[e]),
            .back (eu_back[e]),
            .cnt  (eu_cnt[e])
        );
    end

    dsp_credit #(.CW(CRED_W), .MAXV(ROB_MAX), .UW(IW)) u_rob_cred (
        .clk  (clk),
        .rst  (rst),
        .add  (rob_cred_add),
        .take (n_go),
        .back (IW'(0)),
        .cnt  (rob_cnt)
    );

    always_comb begin
        ret_i = flush ? (int'(occ) + int'(acc)) : int'(n_go);
        if (init_q) ret_i = ret_i + DEPTH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= '0;
            done_q  <= '0;
            init_q  <= 1'b1;
            stall_q <= ST_NONE;
            err_q   <= 1'b0;
            upv_q   <= 1'b0;
            upc_q   <= '0;
        end else begin
            vld_q   <= go;
            done_q  <= done;
            init_q  <= 1'b0;
            err_q   <= over;
            upv_q   <= ret_i != 0;
            upc_q   <= UPC_W'(ret_i);
            if (st_upd) stall_q <= st_val;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WIDTH; i++) grp_q[i] <= win[i];
    end

    always_comb begin
        out_vld = vld_q & ~{WIDTH{flush}};
        for (int i = 0; i < WIDTH; i++) begin
            out_tag[i*TAG_W +: TAG_W] = grp_q[i].tag;
            out_tgt[i*TGT_W +: TGT_W] = grp_q[i].tgt;
        end
        out_done    = done_q & out_vld;
        stall_code  = stall_q;
        push_err    = err_q;
        up_cred_vld = upv_q;
        up_cred_cnt = upc_q;
    end

endmodule

// File: rtl/credit_dispatch_chk.sv
module credit_dispatch_chk #(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 2,
    parameter int CRED_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IW    = $clog2(WIDTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic [IW-1:0]      in_cnt,
    input logic [WIDTH-1:0]   out_vld,
    input logic [WIDTH*3-1:0] out_tgt,
    input logic [WIDTH-1:0]   out_done,
    input logic               push_err,
    input logic [CNT_W-1:0]   occ,
    input logic [CRED_W-1:0]  rob_cnt
);

    // R10: a flush hides the group on the lanes
    p_flush_mask_r10: assert property (@(posedge clk) disable iff (rst)
        flush |-> (out_vld == '0));

    // R4: lanes fill from lane 0 upward without gaps
    p_lane_order_r4: assert property (@(posedge clk) disable iff (rst)
        ((out_vld & (out_vld + 1'b1)) == '0));

    // R3: group never larger than the reorder-buffer tokens at decision time
    p_rob_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (out_vld != '0) |-> ($countones(out_vld) <= int'($past(rob_cnt))));

    // R11: queue occupancy stays within capacity
    p_occ_cap_r11: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH);

    // R11: error flag follows an oversized write
    p_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
        push_err |-> ((int'($past(in_cnt)) + int'($past(occ))) > DEPTH));

    // R6: completion flag marks exactly the reorder-buffer entries
    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        p_done_rob_r6: assert property (@(posedge clk) disable iff (rst)
            out_vld[i] |-> (out_done[i] == (out_tgt[i*3 +: 3] == 3'd5)));
    end

endmodule

bind credit_dispatch credit_dispatch_chk #(
    .DEPTH  (DEPTH),
    .WIDTH  (WIDTH),
    .CRED_W (CRED_W)
) chk_i (.*);

// File: tb/credit_dispatch_tb_top.sv
module credit_dispatch_tb_top;
    import dsp_pkg::*;

    localparam int DEPTH = 8;
    localparam int WIDTH = 2;
    localparam int CW    = 4;
    localparam int IW    = $clog2(WIDTH + 1);
    localparam int UPC_W = $clog2(DEPTH + WIDTH + 1);

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     flush = 1'b0;
    logic [IW-1:0]            in_cnt = '0;
    logic [WIDTH*TAG_W-1:0]   in_tag = '0;
    logic [WIDTH*TGT_W-1:0]   in_tgt = '0;
    logic [NUM_EU*CW-1:0]     eu_cred_add = '0;
    logic [CW-1:0]            rob_cred_add = '0;
    logic                     up_cred_vld;
    logic [UPC_W-1:0]         up_cred_cnt;
    logic [WIDTH-1:0]         out_vld;
    logic [WIDTH*TAG_W-1:0]   out_tag;
    logic [WIDTH*TGT_W-1:0]   out_tgt;
    logic [WIDTH-1:0]         out_done;
    logic [2:0]               stall_code;
    logic                     push_err;

    always #5 clk = ~clk;

    credit_dispatch #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .CRED_W(CW), .CRED_MAX(5), .ROB_MAX(15)
    ) dut_i (
        .clk(clk), .rst(rst), .flush(flush), .in_cnt(in_cnt), .in_tag(in_tag),
        .in_tgt(in_tgt), .eu_cred_add(eu_cred_add), .rob_cred_add(rob_cred_add),
        .up_cred_vld(up_cred_vld), .up_cred_cnt(up_cred_cnt), .out_vld(out_vld),
        .out_tag(out_tag), .out_tgt(out_tgt), .out_done(out_done),
        .stall_code(stall_code), .push_err(push_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int log_tag [256];
    bit log_done [256];
    int log_n = 0;
    int up_sum = 0;
    int base;
    int ub;

    // monitor samples between edges
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (out_vld[i] && log_n < 256) begin
                    log_tag[log_n]  = int'(out_tag[i*TAG_W +: TAG_W]);
                    log_done[log_n] = out_done[i];
                    log_n = log_n + 1;
                end
            end
            if (up_cred_vld) up_sum = up_sum + int'(up_cred_cnt);
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic give_eu(int u, int n);
        eu_cred_add = '0;
        eu_cred_add[u*CW +: CW] = CW'(n);
        step(1);
        eu_cred_add = '0;
    endtask

    task automatic give_rob(int n);
        rob_cred_add = CW'(n);
        step(1);
        rob_cred_add = '0;
    endtask

    task automatic push2(int n, int t0, int g0, int t1, int g1);
        in_cnt = IW'(n);
        in_tag = {8'(t1), 8'(t0)};
        in_tgt = {3'(g1), 3'(g0)};
        step(1);
        in_cnt = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        flush = 1'b0;
        in_cnt = '0;
        eu_cred_add = '0;
        rob_cred_add = '0;
        step(3);
        chk("R1 reset lanes", int'(out_vld), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 init strobe", int'(up_cred_vld), 1);
        chk("R1 init count", int'(up_cred_cnt), DEPTH);
        chk("R1 stall idle", int'(stall_code), 0);
        chk("R1 err idle", int'(push_err), 0);
        @(posedge clk);
        #1;
        step(2);
        base = log_n;
        ub = up_sum;
    endtask

    task automatic t_basic();
        do_reset();
        give_rob(10);
        give_eu(1, 2);
        give_eu(0, 1);
        push2(2, 1, 1, 2, 0);
        push2(2, 3, 1, 4, 1);
        step(6);
        chk("R7 group count", log_n - base, 3);
        chk("R4 order 0", log_tag[base], 1);
        chk("R4 order 1", log_tag[base+1], 2);
        chk("R4 order 2", log_tag[base+2], 3);
        chk("R5 alu0 busy", int'(stall_code), 2);
        chk("R7 slot return", up_sum - ub, 3);
        give_eu(1, 1);
        step(4);
        chk("R7 late dispatch", log_n - base, 4);
        chk("R4 late tag", log_tag[base+3], 4);
        chk("R5 cleared", int'(stall_code), 0);
    endtask

    task automatic t_timing();
        do_reset();
        give_rob(2);
        give_eu(0, 1);
        step(2);
        push2(1, 50, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 lane valid", int'(out_vld), 1);
        chk("R7 lane tag", int'(out_tag[7:0]), 50);
        chk("R6 fpu not done", int'(out_done), 0);
        chk("R7 up strobe", int'(up_cred_vld), 1);
        chk("R7 up count", int'(up_cred_cnt), 1);
        @(negedge clk);
        chk("R7 one cycle", int'(out_vld), 0);
        #4;
        step(1);
    endtask

    task automatic t_block();
        do_reset();
        give_rob(4);
        give_eu(3, 2);
        push2(2, 10, 2, 11, 3);
        step(5);
        chk("R4 head blocks", log_n - base, 0);
        chk("R5 alu1 busy", int'(stall_code), 3);
        flush = 1'b1;
        step(1);
        flush = 1'b0;
        step(3);
        chk("R9 stall held", int'(stall_code), 3);
        chk("R9 slots returned", up_sum - ub, 2);
        give_eu(2, 1);
        step(4);
        chk("R9 queue empty", log_n - base, 0);
    endtask

    task automatic t_rob();
        do_reset();
        give_eu(4, 5);
        give_rob(3);
        push2(2, 30, 4, 31, 4);
        push2(2, 32, 4, 33, 4);
        step(5);
        chk("R3 rob limit", log_n - base, 3);
        chk("R5 rob limit no code", int'(stall_code), 0);
        give_rob(1);
        step(4);
        chk("R8 rob spent", log_n - base, 4);
        chk("R8 last tag", log_tag[base+3], 33);
    endtask

    task automatic t_robtgt();
        do_reset();
        give_rob(4);
        push2(2, 20, 5, 21, 5);
        push2(1, 22, 0, 0, 0);
        step(5);
        chk("R6 rob entries go", log_n - base, 2);
        chk("R6 done 0", int'(log_done[base]), 1);
        chk("R6 done 1", int'(log_done[base+1]), 1);
        chk("R5 fpu busy", int'(stall_code), 1);
        give_eu(0, 1);
        step(4);
        chk("R6 fpu goes", log_n - base, 3);
        chk("R6 fpu not done", int'(log_done[base+2]), 0);
    endtask

    task automatic t_sat();
        do_reset();
        give_rob(12);
        give_eu(3, 4);
        give_eu(3, 4);
        push2(2, 60, 3, 61, 3);
        push2(2, 62, 3, 63, 3);
        push2(2, 64, 3, 65, 3);
        step(6);
        chk("R2 saturated", log_n - base, 5);
        chk("R5 br busy", int'(stall_code), 4);
    endtask

    task automatic t_over();
        do_reset();
        push2(2, 70, 0, 71, 0);
        push2(2, 72, 0, 73, 0);
        push2(2, 74, 0, 75, 0);
        push2(2, 76, 0, 77, 0);
        chk("R11 fit no err", int'(push_err), 0);
        push2(2, 78, 0, 79, 0);
        chk("R11 overflow err", int'(push_err), 1);
        step(1);
        chk("R11 err pulse", int'(push_err), 0);
        flush = 1'b1;
        step(1);
        flush = 1'b0;
        step(3);
        chk("R9 occupancy returned", up_sum - ub, 8);
        give_rob(8);
        give_eu(0, 5);
        step(4);
        chk("R9 nothing left", log_n - base, 0);
    endtask

    task automatic t_mask();
        do_reset();
        give_rob(1);
        give_eu(2, 1);
        step(2);
        push2(1, 40, 2, 0, 0);
        @(posedge clk);
        #1;
        flush = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
        step(3);
        chk("R10 lane masked", log_n - base, 0);
        push2(1, 41, 2, 0, 0);
        step(4);
        chk("R10 rob not restored", log_n - base, 0);
        give_rob(1);
        step(4);
        chk("R10 unit restored", log_n - base, 1);
        chk("R10 tag", log_tag[base], 41);
    endtask

    initial begin
        t_basic();
        t_timing();
        t_block();
        t_rob();
        t_robtgt();
        t_sat();
        t_over();
        t_mask();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule